// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the purely combinational integer datapath of a load-store processor core. It takes two operands, a separate shift count and an operation code, and returns one result word together with a zero indication and a signed-overflow indication. Arithmetic, bitwise logic, one-bit comparisons, loading a constant into the upper half of a word, and all three shift directions are served from one set of inputs. No clock or state is involved, so the result is valid as soon as the inputs settle.

Shifts act on the second operand. The count comes either from the dedicated `shamt` input, which carries the field taken from the instruction word, or from the low five bits of the first operand, which carries a register value. The unit never traps. It only raises a flag that later logic may use to start an exception. Operand decoding, sign extension of immediates and the register file sit outside the block.

Top module: `int_exec_alu`

## Requirements
- R1: Codes 0 (checked add), 1 (plain add), 2 (checked subtract) and 3 (plain subtract) return `opd_a + opd_b` or `opd_a - opd_b` modulo 2^32.
- R2: `ovf` is 1 only for codes 0 and 2. For code 0 it is 1 when both operands share a sign and the sum's sign differs. For code 2 it is 1 when the operand signs differ and the difference's sign differs from `opd_a`. For every other code it is 0.
- R3: Codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of the two operands.
- R4: Code 8 returns 1 when `opd_a` is less than `opd_b` as two's-complement numbers and 0 otherwise. Code 9 does the same comparison as unsigned numbers. Bits 31:1 of the result are always 0 for these codes.
- R5: Codes 10, 11 and 12 shift `opd_b` left, right logically and right arithmetically by `shamt` places (0 to 31).
- R6: Codes 13, 14 and 15 perform the same three shifts, with the count taken from `opd_a[4:0]`. Bits 31:5 of `opd_a` have no effect on these codes.
- R7: Right arithmetic shifts fill the vacated upper bits with bit 31 of `opd_b`. For example, 0xFFFFFFF5 shifted by 2 gives 0xFFFFFFFD. Right logical shifts and left shifts fill with 0.
- R8: Code 16 returns `opd_b[15:0]` in bits 31:16 and zeros in bits 15:0.
- R9: `zero` is 1 exactly when the 32-bit result is 0.
- R10: Codes 17 to 31 return result 0, `zero` = 1 and `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 32 | First operand; its low 5 bits give the count for register-count shifts |
| opd_b | input | 32 | Second operand; the value that is shifted; the source of the upper-half constant |
| shamt | input | 5 | Shift count from the instruction field |
| op | input | 5 | Operation code (0 to 16 defined) |
| result | output | 32 | Result word |
| zero | output | 1 | Result equals zero |
| ovf | output | 1 | Signed overflow on the checked add or subtract |

## Verification
Signed overflow and the signed comparison that depends on it are hard to reach with random operands. They only misbehave near the two extremes of the signed range, where operands of opposite sign straddle 0x7FFFFFFF and 0x80000000. The stimulus therefore crosses every operation code with every pair taken from a set of corner words that includes 0, 1, both signed extremes and all-ones, with the shift count varied alongside. It also uses register-count shifts whose upper operand bits are set, so that any leak of those bits into the count changes the result.

// File: rtl/alu_pkg.sv
// Shared operation encodings for the integer execute unit.
// Assumes a 5-bit operation code; codes above OP_LUI are unused.
package alu_pkg;
    localparam int unsigned OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7,
        OP_SLT  = 5'd8,  OP_SLTU = 5'd9,
        OP_SLL  = 5'd10, OP_SRL  = 5'd11, OP_SRA  = 5'd12,
        OP_SLLV = 5'd13, OP_SRLV = 5'd14, OP_SRAV = 5'd15,
        OP_LUI  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'd0,
        SH_RLOG = 2'd1,
        SH_RARI = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu_arith.sv
// Adder/subtractor shared by add, subtract and both compares.
// Produces the modular sum, the signed-overflow condition and the
// signed and unsigned less-than results. The compares are valid only when sub=1.
module alu_arith #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          ovf,
    output logic          lt_s,
    output logic          lt_u
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   full;

    // One carry chain: invert b and inject a carry-in for subtraction
    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
        sum   = full[DW-1:0];
        ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
        lt_u  = ~full[DW];
        lt_s  = sum[DW-1] ^ ovf;
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise logic unit: AND, OR, XOR and NOR selected by a 2-bit code.
module alu_logic #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]          a,
    input  logic [DW-1:0]          b,
    input  alu_pkg::logic_sel_e    sel,
    output logic [DW-1:0]          y
);
    import alu_pkg::*;

    // Pick one bitwise function
    always_comb begin
        case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
// Logarithmic barrel shifter. It builds one right-shift ladder with a
// selectable fill bit; a left shift reverses the bit order before and after
// that ladder. Assumes DW is a power of two and SHW = log2(DW).
module alu_shift #(
    parameter int DW  = 32,
    parameter int SHW = $clog2(DW)
) (
    input  logic [DW-1:0]           val,
    input  logic [SHW-1:0]          amt,
    input  alu_pkg::shift_kind_e    kind,
    output logic [DW-1:0]           y
);
    import alu_pkg::*;

    logic [DW-1:0] rev_in;
    logic [DW-1:0] rev_out;
    logic [DW-1:0] src;
    logic          fill;
    logic [DW-1:0] stage [SHW+1];

    genvar gi;
    // Bit reversal of the input and of the ladder output
    generate
        for (gi = 0; gi < DW; gi++) begin : g_rev
            assign rev_in[gi]  = val[DW-1-gi];
            assign rev_out[gi] = stage[SHW][DW-1-gi];
        end
    endgenerate

    // Ladder input and fill value depend on shift kind
    always_comb begin
        src  = (kind == SH_LEFT) ? rev_in : val;
        fill = (kind == SH_RARI) & val[DW-1];
    end

    assign stage[0] = src;

    // One stage per count bit, each moving by a power of two
    generate
        for (gi = 0; gi < SHW; gi++) begin : g_stage
            localparam int STEP = 1 << gi;
            assign stage[gi+1] = amt[gi]
                ? {{STEP{fill}}, stage[gi][DW-1:STEP]}
                : stage[gi];
        end
    endgenerate

    // Undo the reversal for left shifts
    assign y = (kind == SH_LEFT) ? rev_out : stage[SHW];
endmodule

// File: rtl/int_exec_alu.sv
// Combinational integer execute unit: add/sub with optional overflow
// reporting, bitwise logic, one-bit compares, upper-half constant load and
// barrel shifts with the count from an instruction field or a register.
// Assumes DW is an even power of two; unused op codes yield zero.
module int_exec_alu #(
    parameter  int DW  = 32,
    localparam int SHW = $clog2(DW),
    localparam int HW  = DW / 2
) (
    input  logic [DW-1:0]           opd_a,
    input  logic [DW-1:0]           opd_b,
    input  logic [SHW-1:0]          shamt,
    input  logic [alu_pkg::OP_W-1:0] op,
    output logic [DW-1:0]           result,
    output logic                    zero,
    output logic                    ovf
);
    import alu_pkg::*;

    logic          ar_sub;
    logic [DW-1:0] ar_sum;
    logic          ar_ovf;
    logic          ar_lt_s;
    logic          ar_lt_u;
    logic_sel_e    lg_sel;
    logic [DW-1:0] lg_y;
    shift_kind_e   sh_kind;
    logic [SHW-1:0] sh_amt;
    logic [DW-1:0] sh_y;

    // Control decode for the three sub-units
    always_comb begin
        ar_sub  = (op == OP_SUB) || (op == OP_SUBU) ||
                  (op == OP_SLT) || (op == OP_SLTU);
        lg_sel  = logic_sel_e'(op[1:0]);
        case (op)
            OP_SLL, OP_SLLV: sh_kind = SH_LEFT;
            OP_SRA, OP_SRAV: sh_kind = SH_RARI;
            default:         sh_kind = SH_RLOG;
        endcase
        sh_amt = (op == OP_SLLV || op == OP_SRLV || op == OP_SRAV)
               ? opd_a[SHW-1:0] : shamt;
    end

    alu_arith #(.DW(DW)) u_arith (
        .a    (opd_a),
        .b    (opd_b),
        .sub  (ar_sub),
        .sum  (ar_sum),
        .ovf  (ar_ovf),
        .lt_s (ar_lt_s),
        .lt_u (ar_lt_u)
    );

    alu_logic #(.DW(DW)) u_logic (
        .a   (opd_a),
        .b   (opd_b),
        .sel (lg_sel),
        .y   (lg_y)
    );

    alu_shift #(.DW(DW), .SHW(SHW)) u_shift (
        .val  (opd_b),
        .amt  (sh_amt),
        .kind (sh_kind),
        .y    (sh_y)
    );

    // Result select and flags
    always_comb begin
        case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = ar_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    result = lg_y;
            OP_SLT:  result = {{(DW-1){1'b0}}, ar_lt_s};
            OP_SLTU: result = {{(DW-1){1'b0}}, ar_lt_u};
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV, OP_SRAV:        result = sh_y;
            OP_LUI:  result = {opd_b[HW-1:0], {HW{1'b0}}};
            default: result = '0;
        endcase
        zero = (result == '0);
        ovf  = ((op == OP_ADD) || (op == OP_SUB)) && ar_ovf;
    end
endmodule

// File: rtl/alu_chk.sv
// Checker for the execute unit: immediate assertions on port values,
// evaluated whenever the inputs settle. The block has no state, so no reset applies.
module alu_chk #(
    parameter  int DW  = 32,
    localparam int SHW = $clog2(DW),
    localparam int HW  = DW / 2
) (
    input logic [DW-1:0]            opd_a,
    input logic [DW-1:0]            opd_b,
    input logic [SHW-1:0]           shamt,
    input logic [alu_pkg::OP_W-1:0] op,
    input logic [DW-1:0]            result,
    input logic                     zero,
    input logic                     ovf
);
    import alu_pkg::*;

    // Property checks on every input change
    always_comb begin
        p_no_overflow_r2: assert ((op == OP_ADD) || (op == OP_SUB) || !ovf)
            else $error("ovf raised for op %0d", op);
        p_zero_flag_r9: assert (zero == (result == '0))
            else $error("zero flag disagrees with result");
        if (op == OP_SLT || op == OP_SLTU) begin
            p_cmp_one_bit_r4: assert (result[DW-1:1] == '0)
                else $error("compare result wider than one bit");
        end
        if (op == OP_LUI) begin
            p_upper_load_r8: assert (result == {opd_b[HW-1:0], {HW{1'b0}}})
                else $error("upper-half load wrong");
        end
        if ((op == OP_SLL || op == OP_SRL || op == OP_SRA) && shamt == '0) begin
            p_shift_by_zero_r5: assert (result == opd_b)
                else $error("shift by zero changed value");
        end
        if (op > OP_LUI) begin
            p_unused_code_r10: assert (result == '0 && zero && !ovf)
                else $error("unused code produced output");
        end
    end
endmodule

bind int_exec_alu alu_chk #(.DW(DW)) u_chk (
    .opd_a  (opd_a),
    .opd_b  (opd_b),
    .shamt  (shamt),
    .op     (op),
    .result (result),
    .zero   (zero),
    .ovf    (ovf)
);

// File: tb/tb_int_exec_alu.sv
// Bench for the execute unit: a behavioural reference model that is
// compared with the unit's outputs on every clock cycle.
module tb_int_exec_alu;
    logic        clk;
    logic        rst_n;
    logic [31:0] opd_a;
    logic [31:0] opd_b;
    logic [4:0]  shamt;
    logic [4:0]  op;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int total = 0;
    int bad   = 0;

    int_exec_alu dut (
        .opd_a  (opd_a),
        .opd_b  (opd_b),
        .shamt  (shamt),
        .op     (op),
        .result (result),
        .zero   (zero),
        .ovf    (ovf)
    );

    // 50 MHz clock
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure
    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Reference model written from the requirements
    function automatic logic [31:0] ref_res(input logic [4:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] s);
        int n;
        n = (o >= 5'd13) ? int'(a[4:0]) : int'(s);
        case (o)
            5'd0, 5'd1: return a + b;
            5'd2, 5'd3: return a - b;
            5'd4:  return a & b;
            5'd5:  return a | b;
            5'd6:  return a ^ b;
            5'd7:  return ~(a | b);
            5'd8:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            5'd9:  return (a < b) ? 32'd1 : 32'd0;
            5'd10, 5'd13: return b << n;
            5'd11, 5'd14: return b >> n;
            5'd12, 5'd15: return 32'($signed(b) >>> n);
            5'd16: return {b[15:0], 16'h0000};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic ref_ovf(input logic [4:0] o, input logic [31:0] a,
                                     input logic [31:0] b);
        logic [31:0] r;
        if (o == 5'd0) begin
            r = a + b;
            return (a[31] == b[31]) && (r[31] != a[31]);
        end
        if (o == 5'd2) begin
            r = a - b;
            return (a[31] != b[31]) && (r[31] != a[31]);
        end
        return 1'b0;
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        if (o <= 5'd3)  return "R1_R2";
        if (o <= 5'd7)  return "R3";
        if (o <= 5'd9)  return "R4";
        if (o <= 5'd12) return "R5_R7";
        if (o <= 5'd15) return "R6_R7";
        if (o == 5'd16) return "R8";
        return "R10";
    endfunction

    // Apply one vector, then compare at the falling edge
    task automatic apply(input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s);
        logic [31:0] er;
        logic        eo;
        @(posedge clk);
        op = o; opd_a = a; opd_b = b; shamt = s;
        er = ref_res(o, a, b, s);
        eo = ref_ovf(o, a, b);
        @(negedge clk);
        total++;
        if (result !== er) begin
            bad++;
            $display("FAIL %s result op=%0d a=%h b=%h s=%0d: actual=%h expected=%h",
                     tag_of(o), o, a, b, s, result, er);
        end
        total++;
        if (ovf !== eo) begin
            bad++;
            $display("FAIL R2 ovf op=%0d a=%h b=%h: actual=%b expected=%b",
                     o, a, b, ovf, eo);
        end
        total++;
        if (zero !== (er == 32'd0)) begin
            bad++;
            $display("FAIL R9 zero op=%0d: actual=%b expected=%b", o, zero, (er == 32'd0));
        end
    endtask

    // Directed check against a literal expectation
    task automatic lit(input string tag, input logic [4:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] s, input logic [31:0] exp_r,
                       input logic exp_v);
        @(posedge clk);
        op = o; opd_a = a; opd_b = b; shamt = s;
        @(negedge clk);
        total++;
        if (result !== exp_r || ovf !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d: actual=%h/%b expected=%h/%b",
                     tag, o, result, ovf, exp_r, exp_v);
        end
    endtask

    logic [31:0] corners [8];

    initial begin
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF; corners[5] = 32'hFFFF_FFF5;
        corners[6] = 32'h0000_8000; corners[7] = 32'h1234_5678;
        rst_n = 1'b0;
        op = '0; opd_a = '0; opd_b = '0; shamt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: idle inputs give a zero add result (R1, R9)
        @(negedge clk);
        total++;
        if (result !== 32'd0 || zero !== 1'b1 || ovf !== 1'b0) begin
            bad++;
            $display("FAIL R9 reset: actual=%h/%b/%b expected=0/1/0", result, zero, ovf);
        end

        // Directed boundary cases
        lit("R2", 5'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 32'h8000_0000, 1'b1);
        lit("R2", 5'd1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0, 32'h8000_0000, 1'b0);
        lit("R2", 5'd2, 32'h8000_0000, 32'h0000_0001, 5'd0, 32'h7FFF_FFFF, 1'b1);
        lit("R4", 5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd1, 1'b0);
        lit("R4", 5'd9, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 32'd0, 1'b0);
        lit("R7", 5'd12, 32'h0, 32'hFFFF_FFF5, 5'd2, 32'hFFFF_FFFD, 1'b0);
        lit("R7", 5'd11, 32'h0, 32'hFFFF_FFF5, 5'd2, 32'h3FFF_FFFD, 1'b0);
        lit("R6", 5'd13, 32'hFFFF_FFE3, 32'h0000_0001, 5'd0, 32'h0000_0008, 1'b0);
        lit("R6", 5'd15, 32'hABCD_EF1F, 32'h8000_0000, 5'd7, 32'hFFFF_FFFF, 1'b0);
        lit("R8", 5'd16, 32'hFFFF_FFFF, 32'hFFFF_1234, 5'd9, 32'h1234_0000, 1'b0);
        lit("R10", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 32'd0, 1'b0);

        // Every code crossed with every corner pair
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(5'(o), corners[i], corners[j], 5'((i * 8 + j + o) % 32));

        // Random operands, including register counts with upper bits set
        for (int k = 0; k < 3000; k++)
            apply(5'($urandom_range(0, 20)), $urandom, $urandom, 5'($urandom));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule